// File: doc/BRIEF.md
# Prefixed Opcode Length Decoder

This block sits in the fetch path of a small 8-bit processor whose opcodes may carry one or two prefix bytes (`CB`, `ED`, `DD`, `FD`). The fetch logic gives it a window of up to four bytes, with byte 0 in bits 7:0 and byte 3 in bits 31:24, and a 2-bit index of the newest byte that holds fetched data. It then answers one of three ways. It may ask for another byte. It may reject the byte pattern as illegal. Or it may accept the instruction and give a coarse group code and the full instruction length, with immediate and displacement bytes included, so the fetcher knows how many operand bytes are still to come.

The length is known once the opcode byte is seen, so in most cases only bytes 0 and 1 are examined. The one exception is the doubly prefixed index-bit form (`DD CB d op` or `FD CB d op`). There the opcode follows a displacement byte. A separate fourth-byte sub-decoder handles it once the index reaches 2, and from that point the caller must keep byte 3 in the window. The classification logic is pure combinational logic. A generate option adds one register stage at the output. With the default settings, each answer appears one clock after the inputs that produced it.

Top module: `oplen_decoder`

## Requirements
- R1: With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst` is high at an edge, the outputs become status 0, group 0 and length 0.
- R2: Status codes are 0 = more bytes needed, 1 = illegal, 2 = legal. The value 3 never appears.
- R3: When the status is not legal, the group and length outputs are both 0. When it is legal, the length is between 1 and 4.
- R4: A non-prefix byte 0 decodes from byte 0 alone. Group codes: 0 control, 1 8-bit load, 2 16-bit load, 3 8-bit arithmetic, 4 16-bit arithmetic, 5 rotate/shift, 6 bit test/set/reset, 7 branch, 8 stack, 9 exchange, 10 port I/O, 11 block transfer. Examples: 00→(0,1), 21→(2,3), 3A→(1,3), CD→(7,3), FE→(3,2), DB→(10,2).
- R5: If byte 0 is a prefix and the index is 0, the status is "more bytes needed".
- R6: With `CB` followed by byte 1, the length is 2. Byte 1 values 00–3F give group 5, except 30–37, which are illegal. Values 40–FF give group 6.
- R7: With `ED` followed by byte 1, only a defined set is legal. 40–7F with low 3 bits 000/001 and byte 1 ≠ 70/71 give (10,2). Low bits 010 give (4,2). Low bits 011 give (2,4). 44 gives (3,2). 45/4D give (7,2). 46/56/5E give (0,2). 47/4F/57/5F give (1,2). 67/6F give (5,2). A0–A3, A8–AB, B0–B3 and B8–BB give (11,2). Every other value is illegal.
- R8: With `DD` or `FD` followed by a byte 1 other than `CB`, these forms are legal:
  - 09/19/29/39/23/2B give (4,2).
  - 21/22/2A give (2,4).
  - 34/35 give (3,3).
  - 36 gives (1,4).
  - A 40–7F byte gives (1,3) when exactly one of its register fields (bits 5:3 and bits 2:0) equals 110.
  - An 80–BF byte with low bits 110 gives (3,3).
  - E1/E5 give (8,2). E3 gives (9,2). E9 gives (7,2). F9 gives (2,2).
  - All other values are illegal, including a second prefix byte.
- R9: For `DD CB` or `FD CB`, index 1 gives "more bytes needed". From index 2 onward, byte 3 decides. It is legal only when its low 3 bits are 110 and it is not 36. Values below 40 give (5,4). Values from 40 upward give (6,4).
- R10: Index value 3 behaves exactly like index 2.
- R11: Bytes beyond the ones the decode needs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| win_i | input | 32 | Fetched byte window, byte 0 in bits 7:0 |
| last_i | input | 2 | Index of the newest fetched byte |
| stat_o | output | 2 | 0 more needed, 1 illegal, 2 legal |
| grp_o | output | 4 | Instruction group code when legal, else 0 |
| len_o | output | 3 | Total instruction length 1–4 when legal, else 0 |

## Verification
Every result of this block (status, group and length) is due exactly one rising edge after the window and index that produce it. The bench drives a new window and index on a falling edge and reads the outputs 1 ns after the next rising edge, so each reading reflects only the vector applied half a cycle before that edge. A directed check reads the outputs just before that edge and expects the previous answer, which pins the delay at exactly one cycle. During reset, the bench reads after an edge with `rst` high and expects zeros even though a legal window is present.

// File: rtl/oplen_pkg.sv
package oplen_pkg;

  localparam int OPW = 8;

  localparam logic [OPW-1:0] PFX_BIT = 8'hCB;
  localparam logic [OPW-1:0] PFX_EXT = 8'hED;
  localparam logic [OPW-1:0] PFX_IXA = 8'hDD;
  localparam logic [OPW-1:0] PFX_IXB = 8'hFD;

  typedef enum logic [1:0] {
    ST_MORE = 2'd0,
    ST_BAD  = 2'd1,
    ST_OK   = 2'd2
  } st_e;

  typedef enum logic [3:0] {
    G_CTRL  = 4'd0,
    G_LD8   = 4'd1,
    G_LD16  = 4'd2,
    G_ALU8  = 4'd3,
    G_ALU16 = 4'd4,
    G_ROT   = 4'd5,
    G_BIT   = 4'd6,
    G_BRAN  = 4'd7,
    G_STACK = 4'd8,
    G_EXCH  = 4'd9,
    G_IO    = 4'd10,
    G_BLOCK = 4'd11
  } grp_e;

  typedef struct packed {
    logic       ok;
    grp_e       grp;
    logic [2:0] len;
  } res_t;

  function automatic res_t r_ok(grp_e g, logic [2:0] n);
    res_t r;
    r.ok  = 1'b1;
    r.grp = g;
    r.len = n;
    return r;
  endfunction

  function automatic res_t r_bad();
    res_t r;
    r.ok  = 1'b0;
    r.grp = G_CTRL;
    r.len = 3'd0;
    return r;
  endfunction

  function automatic logic is_pfx(logic [OPW-1:0] b);
    return (b == PFX_BIT) || (b == PFX_EXT) || (b == PFX_IXA) || (b == PFX_IXB);
  endfunction

endpackage

// File: rtl/oplen_base_dec.sv
module oplen_base_dec
  import oplen_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output res_t           res_o
);
  logic [1:0] x;
  logic [2:0] y;
  logic [2:0] z;
  logic       q;
  logic [1:0] p;

  assign x = op_i[7:6];
  assign y = op_i[5:3];
  assign z = op_i[2:0];
  assign q = y[0];
  assign p = y[2:1];

  always_comb begin
    res_o = r_bad();
    unique case (x)
      2'd0: begin
        unique case (z)
          3'd0: begin
            if (y == 3'd0)      res_o = r_ok(G_CTRL, 3'd1);
            else if (y == 3'd1) res_o = r_ok(G_EXCH, 3'd1);
            else                res_o = r_ok(G_BRAN, 3'd2);
          end
          3'd1: res_o = q ? r_ok(G_ALU16, 3'd1) : r_ok(G_LD16, 3'd3);
          3'd2: begin
            if (y < 3'd4)                      res_o = r_ok(G_LD8, 3'd1);
            else if (y == 3'd4 || y == 3'd5)   res_o = r_ok(G_LD16, 3'd3);
            else                               res_o = r_ok(G_LD8, 3'd3);
          end
          3'd3: res_o = r_ok(G_ALU16, 3'd1);
          3'd4, 3'd5: res_o = r_ok(G_ALU8, 3'd1);
          3'd6: res_o = r_ok(G_LD8, 3'd2);
          default: res_o = (y < 3'd4) ? r_ok(G_ROT, 3'd1) : r_ok(G_CTRL, 3'd1);
        endcase
      end
      2'd1: res_o = (op_i == 8'h76) ? r_ok(G_CTRL, 3'd1) : r_ok(G_LD8, 3'd1);
      2'd2: res_o = r_ok(G_ALU8, 3'd1);
      default: begin
        unique case (z)
          3'd0: res_o = r_ok(G_BRAN, 3'd1);
          3'd1: begin
            if (!q) res_o = r_ok(G_STACK, 3'd1);
            else begin
              unique case (p)
                2'd0:    res_o = r_ok(G_BRAN, 3'd1);
                2'd1:    res_o = r_ok(G_EXCH, 3'd1);
                2'd2:    res_o = r_ok(G_BRAN, 3'd1);
                default: res_o = r_ok(G_LD16, 3'd1);
              endcase
            end
          end
          3'd2: res_o = r_ok(G_BRAN, 3'd3);
          3'd3: begin
            unique case (y)
              3'd0:       res_o = r_ok(G_BRAN, 3'd3);
              3'd1:       res_o = r_bad();
              3'd2, 3'd3: res_o = r_ok(G_IO, 3'd2);
              3'd4, 3'd5: res_o = r_ok(G_EXCH, 3'd1);
              default:    res_o = r_ok(G_CTRL, 3'd1);
            endcase
          end
          3'd4: res_o = r_ok(G_BRAN, 3'd3);
          3'd5: begin
            if (!q)            res_o = r_ok(G_STACK, 3'd1);
            else if (p == 2'd0) res_o = r_ok(G_BRAN, 3'd3);
            else               res_o = r_bad();
          end
          3'd6: res_o = r_ok(G_ALU8, 3'd2);
          default: res_o = r_ok(G_BRAN, 3'd1);
        endcase
      end
    endcase
  end
endmodule

// File: rtl/oplen_ext_dec.sv
module oplen_ext_dec
  import oplen_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output res_t           res_o
);
  logic [1:0] x;
  logic [2:0] y;
  logic [2:0] z;

  assign x = op_i[7:6];
  assign y = op_i[5:3];
  assign z = op_i[2:0];

  always_comb begin
    res_o = r_bad();
    if (x == 2'd1) begin
      unique case (z)
        3'd0, 3'd1: if (y != 3'd6) res_o = r_ok(G_IO, 3'd2);
        3'd2: res_o = r_ok(G_ALU16, 3'd2);
        3'd3: res_o = r_ok(G_LD16, 3'd4);
        3'd4: if (y == 3'd0) res_o = r_ok(G_ALU8, 3'd2);
        3'd5: if (y < 3'd2) res_o = r_ok(G_BRAN, 3'd2);
        3'd6: if (y == 3'd0 || y == 3'd2 || y == 3'd3) res_o = r_ok(G_CTRL, 3'd2);
        default: begin
          if (y < 3'd4)                     res_o = r_ok(G_LD8, 3'd2);
          else if (y == 3'd4 || y == 3'd5)  res_o = r_ok(G_ROT, 3'd2);
        end
      endcase
    end else if (x == 2'd2) begin
      if (z < 3'd4 && y >= 3'd4) res_o = r_ok(G_BLOCK, 3'd2);
    end
  end
endmodule

// File: rtl/oplen_idx_dec.sv
module oplen_idx_dec
  import oplen_pkg::*;
(
  input  logic [OPW-1:0] op_i,
  output res_t           res_o
);
  logic [1:0] x;
  logic [2:0] y;
  logic [2:0] z;
  logic       y_mem;
  logic       z_mem;

  assign x     = op_i[7:6];
  assign y     = op_i[5:3];
  assign z     = op_i[2:0];
  assign y_mem = (y == 3'd6);
  assign z_mem = (z == 3'd6);

  always_comb begin
    res_o = r_bad();
    unique case (op_i)
      8'h09, 8'h19, 8'h29, 8'h39,
      8'h23, 8'h2B:               res_o = r_ok(G_ALU16, 3'd2);
      8'h21, 8'h22, 8'h2A:        res_o = r_ok(G_LD16, 3'd4);
      8'h34, 8'h35:               res_o = r_ok(G_ALU8, 3'd3);
      8'h36:                      res_o = r_ok(G_LD8, 3'd4);
      8'hE1, 8'hE5:               res_o = r_ok(G_STACK, 3'd2);
      8'hE3:                      res_o = r_ok(G_EXCH, 3'd2);
      8'hE9:                      res_o = r_ok(G_BRAN, 3'd2);
      8'hF9:                      res_o = r_ok(G_LD16, 3'd2);
      default: begin
        if (x == 2'd1 && (y_mem != z_mem)) res_o = r_ok(G_LD8, 3'd3);
        else if (x == 2'd2 && z_mem)       res_o = r_ok(G_ALU8, 3'd3);
      end
    endcase
  end
endmodule

// File: rtl/oplen_bitop_dec.sv
module oplen_bitop_dec
  import oplen_pkg::*;
#(
  parameter bit INDEXED = 1'b0
) (
  input  logic [OPW-1:0] op_i,
  output res_t           res_o
);
  localparam logic [2:0] OP_LEN = INDEXED ? 3'd4 : 3'd2;

  logic [1:0] x;
  logic [2:0] y;
  logic       form_ok;
  res_t       cls;

  assign x = op_i[7:6];
  assign y = op_i[5:3];

  generate
    if (INDEXED) begin : g_ix
      assign form_ok = (op_i[2:0] == 3'd6);
    end else begin : g_plain
      assign form_ok = 1'b1;
    end
  endgenerate

  always_comb begin
    if (x != 2'd0)      cls = r_ok(G_BIT, OP_LEN);
    else if (y == 3'd6) cls = r_bad();
    else                cls = r_ok(G_ROT, OP_LEN);
    res_o = form_ok ? cls : r_bad();
  end
endmodule

// File: rtl/oplen_decoder.sv
module oplen_decoder
  import oplen_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BYTE_W*WIN_BYTES-1:0]   win_i,
  input  logic [1:0]                    last_i,
  output logic [1:0]                    stat_o,
  output logic [3:0]                    grp_o,
  output logic [2:0]                    len_o
);
  localparam int WIN_W = BYTE_W * WIN_BYTES;
  localparam int IB_IX = WIN_BYTES - 1;

  logic [BYTE_W-1:0] wb [WIN_BYTES];

  genvar gi;
  generate
    for (gi = 0; gi < WIN_BYTES; gi++) begin : g_split
      assign wb[gi] = win_i[gi*BYTE_W +: BYTE_W];
    end
  endgenerate

  res_t base_res, ext_res, idx_res, cb_res, ib_res, sel;
  logic more;
  st_e  stat_d;
  grp_e grp_d;
  logic [2:0] len_d;

  oplen_base_dec u_base (.op_i(wb[0]), .res_o(base_res));
  oplen_ext_dec  u_ext  (.op_i(wb[1]), .res_o(ext_res));
  oplen_idx_dec  u_idx  (.op_i(wb[1]), .res_o(idx_res));
  oplen_bitop_dec #(.INDEXED(1'b0)) u_cb (.op_i(wb[1]),     .res_o(cb_res));
  oplen_bitop_dec #(.INDEXED(1'b1)) u_ib (.op_i(wb[IB_IX]), .res_o(ib_res));

  always_comb begin
    sel  = r_bad();
    more = 1'b0;
    if (!is_pfx(wb[0])) begin
      sel = base_res;
    end else if (last_i == 2'd0) begin
      more = 1'b1;
    end else if (wb[0] == PFX_BIT) begin
      sel = cb_res;
    end else if (wb[0] == PFX_EXT) begin
      sel = ext_res;
    end else if (wb[1] == PFX_BIT) begin
      if (last_i == 2'd1) more = 1'b1;
      else                sel  = ib_res;
    end else begin
      sel = idx_res;
    end

    if (more)        stat_d = ST_MORE;
    else if (sel.ok) stat_d = ST_OK;
    else             stat_d = ST_BAD;
    grp_d = (stat_d == ST_OK) ? sel.grp : G_CTRL;
    len_d = (stat_d == ST_OK) ? sel.len : 3'd0;
  end

  generate
    if (REG_OUT) begin : g_reg
      st_e        stat_q;
      grp_e       grp_q;
      logic [2:0] len_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          stat_q <= ST_MORE;
          grp_q  <= G_CTRL;
          len_q  <= 3'd0;
        end else begin
          stat_q <= stat_d;
          grp_q  <= grp_d;
          len_q  <= len_d;
        end
      end
      assign stat_o = stat_q;
      assign grp_o  = grp_q;
      assign len_o  = len_q;
    end else begin : g_comb
      assign stat_o = stat_d;
      assign grp_o  = grp_d;
      assign len_o  = len_d;
    end
  endgenerate

  logic [WIN_W-1:0] unused_win;
  assign unused_win = win_i;
endmodule

// File: rtl/oplen_decoder_chk.sv
module oplen_decoder_chk #(
  parameter int BYTE_W    = 8,
  parameter int WIN_BYTES = 4,
  parameter bit REG_OUT   = 1'b1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [BYTE_W*WIN_BYTES-1:0] win_i,
  input logic [1:0]                  last_i,
  input logic [1:0]                  stat_o,
  input logic [3:0]                  grp_o,
  input logic [2:0]                  len_o
);
  logic [1:0] up;
  logic       b0_pfx;
  logic       ixbit;

  always_ff @(posedge clk) begin
    if (rst)             up <= 2'd0;
    else if (up != 2'd3) up <= up + 2'd1;
  end

  assign b0_pfx = (win_i[7:0] == 8'hCB) || (win_i[7:0] == 8'hED) ||
                  (win_i[7:0] == 8'hDD) || (win_i[7:0] == 8'hFD);
  assign ixbit  = ((win_i[7:0] == 8'hDD) || (win_i[7:0] == 8'hFD)) &&
                  (win_i[15:8] == 8'hCB);

  p_stat_code_r2: assert property (@(posedge clk) disable iff (rst)
    stat_o != 2'd3);

  p_idle_fields_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_o != 2'd2) |-> (grp_o == 4'd0 && len_o == 3'd0));

  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_o == 2'd2) |-> (len_o >= 3'd1 && len_o <= 3'd4));

  generate
    if (REG_OUT) begin : g_seq
      p_reset_r1: assert property (@(posedge clk)
        rst |=> (stat_o == 2'd0 && grp_o == 4'd0 && len_o == 3'd0));

      p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (up >= 2'd2 && win_i == $past(win_i) && last_i == $past(last_i))
        |=> ($stable(stat_o) && $stable(grp_o) && $stable(len_o)));

      p_prefix_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (last_i == 2'd0 && b0_pfx) |=> (stat_o == 2'd0));

      p_ixbit_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (last_i == 2'd1 && ixbit) |=> (stat_o == 2'd0));

      p_ixbit_len_r9: assert property (@(posedge clk) disable iff (rst)
        (last_i >= 2'd2 && ixbit) |=> (stat_o == 2'd1 || (stat_o == 2'd2 && len_o == 3'd4)));
    end else begin : g_cmb
      p_prefix_wait_r5: assert property (@(posedge clk) disable iff (rst)
        (last_i == 2'd0 && b0_pfx) |-> (stat_o == 2'd0));

      p_ixbit_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (last_i == 2'd1 && ixbit) |-> (stat_o == 2'd0));

      p_ixbit_len_r9: assert property (@(posedge clk) disable iff (rst)
        (last_i >= 2'd2 && ixbit) |-> (stat_o == 2'd1 || (stat_o == 2'd2 && len_o == 3'd4)));
    end
  endgenerate
endmodule

bind oplen_decoder oplen_decoder_chk #(
  .BYTE_W(BYTE_W), .WIN_BYTES(WIN_BYTES), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/test_oplen_decoder.sv
`timescale 1ns/1ps
module test_oplen_decoder;
  localparam int NV = 62;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] win_i = 32'h0;
  logic [1:0]  last_i = 2'd0;
  logic [1:0]  stat_o;
  logic [3:0]  grp_o;
  logic [2:0]  len_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  oplen_decoder i_oplen_decoder (
    .clk(clk), .rst(rst), .win_i(win_i), .last_i(last_i),
    .stat_o(stat_o), .grp_o(grp_o), .len_o(len_o)
  );

  // {req[3:0], win[31:0], last[1:0], stat[1:0], grp[3:0], len[2:0]}
  localparam logic [46:0] VEC [NV] = '{
    // R4 unprefixed
    {4'd4, 32'h00000000, 2'd0, 2'd2, 4'd0,  3'd1},
    {4'd4, 32'h00000076, 2'd0, 2'd2, 4'd0,  3'd1},
    {4'd4, 32'h00000021, 2'd0, 2'd2, 4'd2,  3'd3},
    {4'd4, 32'h0000003A, 2'd0, 2'd2, 4'd1,  3'd3},
    {4'd4, 32'h00000006, 2'd0, 2'd2, 4'd1,  3'd2},
    {4'd4, 32'h00000010, 2'd0, 2'd2, 4'd7,  3'd2},
    {4'd4, 32'h000000C3, 2'd0, 2'd2, 4'd7,  3'd3},
    {4'd4, 32'h000000CD, 2'd0, 2'd2, 4'd7,  3'd3},
    {4'd4, 32'h000000DB, 2'd0, 2'd2, 4'd10, 3'd2},
    {4'd4, 32'h00000080, 2'd0, 2'd2, 4'd3,  3'd1},
    {4'd4, 32'h000000FE, 2'd0, 2'd2, 4'd3,  3'd2},
    {4'd4, 32'h000000C5, 2'd0, 2'd2, 4'd8,  3'd1},
    {4'd4, 32'h000000D9, 2'd0, 2'd2, 4'd9,  3'd1},
    {4'd4, 32'h00000007, 2'd0, 2'd2, 4'd5,  3'd1},
    {4'd4, 32'h00000009, 2'd0, 2'd2, 4'd4,  3'd1},
    {4'd4, 32'h0000003E, 2'd0, 2'd2, 4'd1,  3'd2},
    // R5 prefix alone
    {4'd5, 32'h000000CB, 2'd0, 2'd0, 4'd0,  3'd0},
    {4'd5, 32'h000000ED, 2'd0, 2'd0, 4'd0,  3'd0},
    {4'd5, 32'h000000DD, 2'd0, 2'd0, 4'd0,  3'd0},
    {4'd5, 32'h000000FD, 2'd0, 2'd0, 4'd0,  3'd0},
    // R6 CB forms
    {4'd6, 32'h000000CB, 2'd1, 2'd2, 4'd5,  3'd2},
    {4'd6, 32'h000036CB, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd6, 32'h000038CB, 2'd1, 2'd2, 4'd5,  3'd2},
    {4'd6, 32'h00007ECB, 2'd1, 2'd2, 4'd6,  3'd2},
    {4'd6, 32'h0000FFCB, 2'd1, 2'd2, 4'd6,  3'd2},
    // R7 ED forms
    {4'd7, 32'h0000B0ED, 2'd1, 2'd2, 4'd11, 3'd2},
    {4'd7, 32'h000043ED, 2'd1, 2'd2, 4'd2,  3'd4},
    {4'd7, 32'h000044ED, 2'd1, 2'd2, 4'd3,  3'd2},
    {4'd7, 32'h00004DED, 2'd1, 2'd2, 4'd7,  3'd2},
    {4'd7, 32'h000078ED, 2'd1, 2'd2, 4'd10, 3'd2},
    {4'd7, 32'h000070ED, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd7, 32'h000000ED, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd7, 32'h000046ED, 2'd1, 2'd2, 4'd0,  3'd2},
    {4'd7, 32'h00004EED, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd7, 32'h000057ED, 2'd1, 2'd2, 4'd1,  3'd2},
    {4'd7, 32'h00006FED, 2'd1, 2'd2, 4'd5,  3'd2},
    {4'd7, 32'h00004AED, 2'd1, 2'd2, 4'd4,  3'd2},
    // R8 index forms
    {4'd8, 32'h000021DD, 2'd1, 2'd2, 4'd2,  3'd4},
    {4'd8, 32'h000036FD, 2'd1, 2'd2, 4'd1,  3'd4},
    {4'd8, 32'h00007EDD, 2'd1, 2'd2, 4'd1,  3'd3},
    {4'd8, 32'h000077DD, 2'd1, 2'd2, 4'd1,  3'd3},
    {4'd8, 32'h000076DD, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd8, 32'h000086DD, 2'd1, 2'd2, 4'd3,  3'd3},
    {4'd8, 32'h000034DD, 2'd1, 2'd2, 4'd3,  3'd3},
    {4'd8, 32'h0000E9DD, 2'd1, 2'd2, 4'd7,  3'd2},
    {4'd8, 32'h0000E5DD, 2'd1, 2'd2, 4'd8,  3'd2},
    {4'd8, 32'h0000DDDD, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd8, 32'h0000EDFD, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd8, 32'h000044DD, 2'd1, 2'd1, 4'd0,  3'd0},
    {4'd8, 32'h000023FD, 2'd1, 2'd2, 4'd4,  3'd2},
    {4'd8, 32'h0000E3DD, 2'd1, 2'd2, 4'd9,  3'd2},
    // R9 index-bit forms
    {4'd9, 32'h0000CBDD, 2'd1, 2'd0, 4'd0,  3'd0},
    {4'd9, 32'h0605CBFD, 2'd2, 2'd2, 4'd5,  3'd4},
    {4'd9, 32'h4680CBDD, 2'd2, 2'd2, 4'd6,  3'd4},
    {4'd9, 32'h3600CBDD, 2'd2, 2'd1, 4'd0,  3'd0},
    {4'd9, 32'h077FCBDD, 2'd2, 2'd1, 4'd0,  3'd0},
    {4'd9, 32'hFE01CBDD, 2'd2, 2'd2, 4'd6,  3'd4},
    // R10 index 3
    {4'd10, 32'h16AACBFD, 2'd3, 2'd2, 4'd5, 3'd4},
    {4'd10, 32'hFFFF0000, 2'd3, 2'd2, 4'd0, 3'd1},
    // R11 trailing bytes ignored
    {4'd11, 32'hDDCBED3E, 2'd2, 2'd2, 4'd1, 3'd2},
    {4'd11, 32'hFFFF7ECB, 2'd2, 2'd2, 4'd6, 3'd2},
    {4'd11, 32'h1234B0ED, 2'd3, 2'd2, 4'd11, 3'd2}
  };

  task automatic chk(input string tag, input logic [1:0] es,
                     input logic [3:0] eg, input logic [2:0] el);
    checks++;
    if (stat_o !== es || grp_o !== eg || len_o !== el) begin
      fails++;
      $display("FAIL %s: actual stat=%0d grp=%0d len=%0d expected stat=%0d grp=%0d len=%0d",
               tag, stat_o, grp_o, len_o, es, eg, el);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [1:0] l);
    @(negedge clk);
    win_i  = w;
    last_i = l;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    // R1: reset state, with a legal window present
    win_i  = 32'h00000021;
    last_i = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset", 2'd0, 4'd0, 3'd0);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 first after reset", 2'd2, 4'd2, 3'd3);

    // R1: one-cycle latency, old answer held until the edge
    @(negedge clk);
    win_i = 32'h000000FE;
    #1;
    chk("R1 before edge", 2'd2, 4'd2, 3'd3);
    @(posedge clk);
    #1;
    chk("R1 after edge", 2'd2, 4'd3, 3'd2);

    // Table walk (R2, R3 and the decode requirements)
    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      string tag;
      v = VEC[i];
      apply(v[42:11], v[10:9]);
      tag = $sformatf("R%0d vec %0d", v[46:43], i);
      chk(tag, v[8:7], v[6:3], v[2:0]);
      checks++;
      if (stat_o == 2'd3) begin
        fails++;
        $display("FAIL R2 vec %0d: actual stat=3 expected 0..2", i);
      end
      checks++;
      if (stat_o == 2'd2 && (len_o < 3'd1 || len_o > 3'd4)) begin
        fails++;
        $display("FAIL R3 vec %0d: actual len=%0d expected 1..4", i, len_o);
      end
    end

    // R11: trailing bytes varied under the same CB opcode
    apply(32'h00007ECB, 2'd1);
    chk("R11 base", 2'd2, 4'd6, 3'd2);
    apply(32'hA5C37ECB, 2'd1);
    chk("R11 junk", 2'd2, 4'd6, 3'd2);

    // R9: the same index-bit bytes stepping through the index values
    apply(32'h4E10CBDD, 2'd0);
    chk("R9 step0", 2'd0, 4'd0, 3'd0);
    apply(32'h4E10CBDD, 2'd1);
    chk("R9 step1", 2'd0, 4'd0, 3'd0);
    apply(32'h4E10CBDD, 2'd2);
    chk("R9 step2", 2'd2, 4'd6, 3'd4);

    // R1: reset asserted mid-run clears the outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 mid reset", 2'd0, 4'd0, 3'd0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule